// File: doc/BRIEF.md
# PCI Function Configuration Header and BAR Register File

This block holds the type-0 configuration header of a single PCI device function. Configuration cycles are already decoded from the bus and arrive as a dword address, four byte enables and 32 bits of write data. Each access is either a write or a read. Reads return their data one cycle later. The block stores six Base Address Registers and the writable header fields: command, status, cache line size, latency timer and interrupt line. The identification dwords are constants set by parameters.

Each BAR has a build-time size, which is zero or a power of two, and build-time type bits. Software finds the size by writing all ones and reading back the size mask. It then programs a base. The type bits in the low part of the register cannot be overwritten. Once a base is programmed, the BAR's decode outputs carry that base, its size and its space (I/O or memory), and a one-cycle pulse announces that the decode map has changed. A BAR can instead be fixed at build time as a legacy I/O window. Such a BAR decodes from reset at a parameter address, reads as zero and ignores writes.

The function's configuration base address is a parameter. The all-ones value means the function has no configuration range. In that case it never claims an access.

Top module: `pci_cfg_bar_file`

## Requirements
- R1: After reset, command, status, cache line size, latency timer and interrupt line are zero. Each live BAR reads its type bits (I/O type value 0x1; memory type bits [3:0] from the parameter). No live BAR is enabled, and mapChange is low.
- R2: A write with all four byte enables and data 0xFFFFFFFF to a live BAR stores (~(size-1) & ~mask) | (old & mask). This write leaves the decode outputs unchanged and raises no mapChange.
- R3: The mask is 0x3 when bit 0 of the BAR's current value is 1 (I/O) and 0xF otherwise (memory). Any other full write stores (new & ~mask) | (old & mask).
- R4: A full non-probe write whose masked value (new & ~mask) is nonzero does three things. It sets that BAR's barBase to the masked value and sets barEnable. It sets barIsIo to bit 0 of the BAR's value before the write. It also makes mapChange high for exactly the one cycle after the write edge.
- R5: A full non-probe write whose masked value is zero leaves only the type bits in the register. The decode outputs do not change and no mapChange pulse is raised.
- R6: A legacy BAR always reads zero and ignores writes. Its barEnable and barIsIo are 1 from reset, and its barBase is its fixed parameter address.
- R7: A BAR of size zero always reads zero, including after a probe, and is never enabled.
- R8: At dword 0x0C, byte 0 holds the cache line size and byte 1 the latency timer. At dword 0x3C, byte 0 holds the interrupt line. A byte write changes only its own field.
- R9: At dword 0x04, bytes 1:0 hold command and bytes 3:2 hold status. A write to one lane pair leaves the other unchanged.
- R10: A BAR write without all four byte enables set changes neither the register nor the decode outputs.
- R11: cfgClaim is high for an access whose address bits above bit 7 match the configuration base. A claimed read gives cfgRdValid with data in the next cycle, and dword 0x00 returns the identification parameter. An unclaimed access changes nothing and gives no cfgRdValid.
- R12: With an all-ones configuration base the block never claims, never returns read data and ignores all writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgValid | input | 1 | Configuration access this cycle |
| cfgWrite | input | 1 | 1 = write, 0 = read |
| cfgAddr | input | ADDR_W-2 | Dword address (byte address bits ADDR_W-1:2) |
| cfgBe | input | 4 | Byte enables for the write |
| cfgWdata | input | 32 | Write data |
| cfgClaim | output | 1 | Access falls in this function's range |
| cfgRdValid | output | 1 | Read data valid (one cycle after the read) |
| cfgRdata | output | 32 | Read data |
| barBase | output | 6*32 | Decode base per BAR, BAR n at bits [32n+31:32n] |
| barSize | output | 6*32 | Decode size per BAR |
| barEnable | output | 6 | Decode enabled per BAR |
| barIsIo | output | 6 | Decode window is in I/O space |
| mapChange | output | 1 | One-cycle pulse when a decode base changes |

## Verification
The bench builds two instances. The first uses one BAR of each kind: a 16-byte I/O BAR, a 4 KiB memory BAR, a 256-byte prefetchable memory BAR, an unused BAR, a legacy 8-byte I/O window and a 1 MiB memory BAR. This lets a single sweep of probe, base, zero and partial writes over all six slots cover both masks, every type-bit pattern, the size-zero and legacy paths, and masks that reach high bits. The second instance has an all-ones configuration base, so the same stimulus also shows that a function without a range claims nothing.

// File: rtl/pcicfg_pkg.sv
package pcicfg_pkg;
  localparam int NUM_BAR   = 6;
  localparam int IDX_W     = 6;      // dword index inside 256-byte space
  localparam int BAR_IDX0  = 4;      // dword index of the first BAR
  localparam logic [31:0] IO_MASK  = 32'h3;
  localparam logic [31:0] MEM_MASK = 32'hF;

  typedef struct packed {
    logic [NUM_BAR-1:0] barWr;
    logic               cmdWr;
    logic               lineWr;
    logic               intWr;
    logic               rdEn;
    logic [IDX_W-1:0]   dwIdx;
  } cfg_strobe_t;
endpackage

// File: rtl/pcicfg_ctrl.sv
module pcicfg_ctrl
  import pcicfg_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter logic [ADDR_W-1:0] CFG_BASE = 32'h0000_0800
) (
  input  logic              cfgValid,
  input  logic              cfgWrite,
  input  logic [ADDR_W-1:2] cfgAddr,
  output logic              cfgClaim,
  output cfg_strobe_t       strb
);
  localparam int HI = ADDR_W - 1;
  localparam int LO = IDX_W + 2;
  localparam bit BASE_OK = (CFG_BASE != '1);

  logic [IDX_W-1:0] idx;
  logic wrHit;

  assign idx      = cfgAddr[LO-1:2];
  assign cfgClaim = BASE_OK && cfgValid && (cfgAddr[HI:LO] == CFG_BASE[HI:LO]);
  assign wrHit    = cfgClaim && cfgWrite;

  for (genvar n = 0; n < NUM_BAR; n++) begin : g_barsel
    assign strb.barWr[n] = wrHit && (idx == IDX_W'(BAR_IDX0 + n));
  end

  assign strb.cmdWr  = wrHit && (idx == IDX_W'(1));
  assign strb.lineWr = wrHit && (idx == IDX_W'(3));
  assign strb.intWr  = wrHit && (idx == IDX_W'(15));
  assign strb.rdEn   = cfgClaim && !cfgWrite;
  assign strb.dwIdx  = idx;
endmodule

// File: rtl/pcicfg_datapath.sv
module pcicfg_datapath
  import pcicfg_pkg::*;
#(
  parameter logic [NUM_BAR-1:0][31:0] BAR_SIZE    = {32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h1000},
  parameter logic [NUM_BAR-1:0][3:0]  BAR_TYPE    = {4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0},
  parameter logic [NUM_BAR-1:0]       BAR_LEGACY  = '0,
  parameter logic [NUM_BAR-1:0][31:0] LEGACY_BASE = '0,
  parameter logic [31:0]              DEV_ID      = 32'h1234_ABCD,
  parameter logic [31:0]              CLASS_REV   = 32'h0200_0001
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  cfg_strobe_t            strb,
  input  logic [3:0]             cfgBe,
  input  logic [31:0]            cfgWdata,
  output logic                   cfgRdValid,
  output logic [31:0]            cfgRdata,
  output logic [NUM_BAR*32-1:0]  barBase,
  output logic [NUM_BAR*32-1:0]  barSize,
  output logic [NUM_BAR-1:0]     barEnable,
  output logic [NUM_BAR-1:0]     barIsIo,
  output logic                   mapChange
);
  logic [31:0] barVal [NUM_BAR];
  logic [NUM_BAR-1:0] chg;
  logic probe;

  assign probe = (cfgWdata == '1);

  for (genvar n = 0; n < NUM_BAR; n++) begin : g_bar
    if (BAR_SIZE[n] != 0 && (BAR_SIZE[n] & (BAR_SIZE[n] - 32'd1)) != 0) begin : g_badsize
      $error("BAR size must be zero or a power of two");
    end

    if (BAR_LEGACY[n]) begin : g_legacy
      assign barVal[n] = '0;
      assign barBase[n*32 +: 32] = LEGACY_BASE[n];
      assign barSize[n*32 +: 32] = BAR_SIZE[n];
      assign barEnable[n] = 1'b1;
      assign barIsIo[n]   = 1'b1;
      assign chg[n]       = 1'b0;
    end else if (BAR_SIZE[n] == 0) begin : g_unused
      assign barVal[n] = '0;
      assign barBase[n*32 +: 32] = '0;
      assign barSize[n*32 +: 32] = '0;
      assign barEnable[n] = 1'b0;
      assign barIsIo[n]   = 1'b0;
      assign chg[n]       = 1'b0;
    end else begin : g_live
      logic [31:0] regQ, baseQ, mask, src, newVal, masked;
      logic enQ, ioQ, chgQ, hit;

      assign mask   = regQ[0] ? IO_MASK : MEM_MASK;
      assign src    = probe ? ~(BAR_SIZE[n] - 32'd1) : cfgWdata;
      assign newVal = (src & ~mask) | (regQ & mask);
      assign masked = cfgWdata & ~mask;
      assign hit    = strb.barWr[n] && (cfgBe == 4'hF);

      always_ff @(posedge clk) begin
        if (!rstN) begin
          regQ  <= {28'h0, BAR_TYPE[n]};
          baseQ <= '0;
          enQ   <= 1'b0;
          ioQ   <= 1'b0;
          chgQ  <= 1'b0;
        end else begin
          chgQ <= 1'b0;
          if (hit) begin
            regQ <= newVal;
            if (!probe && masked != '0) begin
              baseQ <= masked;
              enQ   <= 1'b1;
              ioQ   <= regQ[0];
              chgQ  <= 1'b1;
            end
          end
        end
      end

      assign barVal[n] = regQ;
      assign barBase[n*32 +: 32] = baseQ;
      assign barSize[n*32 +: 32] = BAR_SIZE[n];
      assign barEnable[n] = enQ;
      assign barIsIo[n]   = ioQ;
      assign chg[n]       = chgQ;
    end
  end

  assign mapChange = |chg;

  // header registers
  logic [15:0] commandQ, statusQ;
  logic [7:0]  cacheLineQ, latTimerQ, intLineQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      commandQ   <= '0;
      statusQ    <= '0;
      cacheLineQ <= '0;
      latTimerQ  <= '0;
      intLineQ   <= '0;
    end else begin
      if (strb.cmdWr) begin
        if (cfgBe[0]) commandQ[7:0]  <= cfgWdata[7:0];
        if (cfgBe[1]) commandQ[15:8] <= cfgWdata[15:8];
        if (cfgBe[2]) statusQ[7:0]   <= cfgWdata[23:16];
        if (cfgBe[3]) statusQ[15:8]  <= cfgWdata[31:24];
      end
      if (strb.lineWr) begin
        if (cfgBe[0]) cacheLineQ <= cfgWdata[7:0];
        if (cfgBe[1]) latTimerQ  <= cfgWdata[15:8];
      end
      if (strb.intWr && cfgBe[0]) intLineQ <= cfgWdata[7:0];
    end
  end

  // read path
  logic [31:0] rdMux;
  always_comb begin
    rdMux = '0;
    case (strb.dwIdx)
      IDX_W'(0):  rdMux = DEV_ID;
      IDX_W'(1):  rdMux = {statusQ, commandQ};
      IDX_W'(2):  rdMux = CLASS_REV;
      IDX_W'(3):  rdMux = {16'h0, latTimerQ, cacheLineQ};
      IDX_W'(15): rdMux = {24'h0, intLineQ};
      default: begin
        for (int i = 0; i < NUM_BAR; i++) begin
          if (strb.dwIdx == IDX_W'(BAR_IDX0 + i)) rdMux = barVal[i];
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgRdValid <= 1'b0;
      cfgRdata   <= '0;
    end else begin
      cfgRdValid <= strb.rdEn;
      if (strb.rdEn) cfgRdata <= rdMux;
    end
  end
endmodule

// File: rtl/pci_cfg_bar_file.sv
module pci_cfg_bar_file
  import pcicfg_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter logic [ADDR_W-1:0]        CFG_BASE    = 32'h0000_0800,
  parameter logic [NUM_BAR-1:0][31:0] BAR_SIZE    = {32'h0, 32'h0, 32'h0, 32'h0, 32'h0, 32'h1000},
  parameter logic [NUM_BAR-1:0][3:0]  BAR_TYPE    = {4'h0, 4'h0, 4'h0, 4'h0, 4'h0, 4'h0},
  parameter logic [NUM_BAR-1:0]       BAR_LEGACY  = '0,
  parameter logic [NUM_BAR-1:0][31:0] LEGACY_BASE = '0,
  parameter logic [31:0]              DEV_ID      = 32'h1234_ABCD,
  parameter logic [31:0]              CLASS_REV   = 32'h0200_0001
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  cfgValid,
  input  logic                  cfgWrite,
  input  logic [ADDR_W-1:2]     cfgAddr,
  input  logic [3:0]            cfgBe,
  input  logic [31:0]           cfgWdata,
  output logic                  cfgClaim,
  output logic                  cfgRdValid,
  output logic [31:0]           cfgRdata,
  output logic [NUM_BAR*32-1:0] barBase,
  output logic [NUM_BAR*32-1:0] barSize,
  output logic [NUM_BAR-1:0]    barEnable,
  output logic [NUM_BAR-1:0]    barIsIo,
  output logic                  mapChange
);
  cfg_strobe_t strb;

  pcicfg_ctrl #(.ADDR_W(ADDR_W), .CFG_BASE(CFG_BASE)) ctrl_i (
    .cfgValid(cfgValid), .cfgWrite(cfgWrite), .cfgAddr(cfgAddr),
    .cfgClaim(cfgClaim), .strb(strb)
  );

  pcicfg_datapath #(
    .BAR_SIZE(BAR_SIZE), .BAR_TYPE(BAR_TYPE), .BAR_LEGACY(BAR_LEGACY),
    .LEGACY_BASE(LEGACY_BASE), .DEV_ID(DEV_ID), .CLASS_REV(CLASS_REV)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .cfgBe(cfgBe), .cfgWdata(cfgWdata),
    .cfgRdValid(cfgRdValid), .cfgRdata(cfgRdata), .barBase(barBase),
    .barSize(barSize), .barEnable(barEnable), .barIsIo(barIsIo),
    .mapChange(mapChange)
  );
endmodule

// File: rtl/pcicfg_chk.sv
module pcicfg_chk
  import pcicfg_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter logic [ADDR_W-1:0]  CFG_BASE   = 32'h0000_0800,
  parameter logic [NUM_BAR-1:0] BAR_LEGACY = '0
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  cfgValid,
  input logic                  cfgWrite,
  input logic                  cfgClaim,
  input logic                  cfgRdValid,
  input logic [NUM_BAR*32-1:0] barBase,
  input logic [NUM_BAR-1:0]    barEnable,
  input logic [NUM_BAR-1:0]    barIsIo,
  input logic                  mapChange
);
  // R4
  map_pulse_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    mapChange |=> !mapChange);

  // R4
  map_pulse_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    mapChange |-> $past(cfgValid && cfgWrite && cfgClaim));

  // R2
  base_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(cfgValid && cfgWrite && cfgClaim) |=> $stable(barBase) && !mapChange);

  // R4
  enable_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((barEnable & $past(barEnable)) == $past(barEnable)));

  // R11
  read_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    cfgRdValid |-> $past(cfgValid && !cfgWrite && cfgClaim));

  // R12
  no_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    cfgClaim |-> (CFG_BASE != '1));

  // R6
  legacy_fixed_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((barEnable & barIsIo & BAR_LEGACY) == BAR_LEGACY));
endmodule

bind pci_cfg_bar_file pcicfg_chk #(
  .ADDR_W(ADDR_W), .CFG_BASE(CFG_BASE), .BAR_LEGACY(BAR_LEGACY)
) chk_i (
  .clk(clk), .rstN(rstN), .cfgValid(cfgValid), .cfgWrite(cfgWrite),
  .cfgClaim(cfgClaim), .cfgRdValid(cfgRdValid), .barBase(barBase),
  .barEnable(barEnable), .barIsIo(barIsIo), .mapChange(mapChange)
);

// File: tb/pci_cfg_bar_file_tb.sv
module pci_cfg_bar_file_tb_top;
  localparam logic [5:0][31:0] SIZES  = {32'h0010_0000, 32'h8, 32'h0, 32'h100, 32'h1000, 32'h10};
  localparam logic [5:0][3:0]  TYPES  = {4'h0, 4'h0, 4'h0, 4'h8, 4'h0, 4'h1};
  localparam logic [5:0]       LEGACY = 6'b010000;
  localparam logic [5:0][31:0] LBASE  = {32'h0, 32'h1F0, 32'h0, 32'h0, 32'h0, 32'h0};
  localparam logic [31:0]      IDV    = 32'hC0DE_1AB5;
  localparam logic [31:0]      ONES   = 32'hFFFF_FFFF;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgValid = 1'b0, cfgWrite = 1'b0;
  logic [31:2] cfgAddr = '0;
  logic [3:0]  cfgBe = '0;
  logic [31:0] cfgWdata = '0;

  logic cfgClaim, cfgRdValid, mapChange;
  logic [31:0] cfgRdata;
  logic [191:0] barBase, barSize;
  logic [5:0] barEnable, barIsIo;

  logic offClaim, offRdValid, offMapChange;
  logic [31:0] offRdata;
  logic [191:0] offBase, offSize;
  logic [5:0] offEnable, offIsIo;

  always #4 clk = ~clk;

  pci_cfg_bar_file #(
    .CFG_BASE(32'h0000_0800), .BAR_SIZE(SIZES), .BAR_TYPE(TYPES),
    .BAR_LEGACY(LEGACY), .LEGACY_BASE(LBASE), .DEV_ID(IDV)
  ) dut_i (
    .clk(clk), .rstN(rstN), .cfgValid(cfgValid), .cfgWrite(cfgWrite),
    .cfgAddr(cfgAddr), .cfgBe(cfgBe), .cfgWdata(cfgWdata),
    .cfgClaim(cfgClaim), .cfgRdValid(cfgRdValid), .cfgRdata(cfgRdata),
    .barBase(barBase), .barSize(barSize), .barEnable(barEnable),
    .barIsIo(barIsIo), .mapChange(mapChange)
  );

  pci_cfg_bar_file #(
    .CFG_BASE(32'hFFFF_FFFF), .BAR_SIZE(SIZES), .BAR_TYPE(TYPES),
    .BAR_LEGACY(LEGACY), .LEGACY_BASE(LBASE), .DEV_ID(IDV)
  ) dut_off_i (
    .clk(clk), .rstN(rstN), .cfgValid(cfgValid), .cfgWrite(cfgWrite),
    .cfgAddr(cfgAddr), .cfgBe(cfgBe), .cfgWdata(cfgWdata),
    .cfgClaim(offClaim), .cfgRdValid(offRdValid), .cfgRdata(offRdata),
    .barBase(offBase), .barSize(offSize), .barEnable(offEnable),
    .barIsIo(offIsIo), .mapChange(offMapChange)
  );

  int nChecks = 0, nFail = 0, cycles = 0;
  bit done = 0;

  logic [31:0] expBar [6];
  logic [31:0] expBase [6];
  logic        expEn [6];
  logic        expIo [6];

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cfgWr(input logic [31:0] addr, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    cfgValid = 1'b1; cfgWrite = 1'b1; cfgAddr = addr[31:2]; cfgBe = be; cfgWdata = d;
    @(negedge clk);
    cfgValid = 1'b0; cfgWrite = 1'b0; cfgBe = '0;
  endtask

  task automatic cfgRd(input logic [31:0] addr, output logic [31:0] d, output logic v, output logic cl);
    @(negedge clk);
    cfgValid = 1'b1; cfgWrite = 1'b0; cfgAddr = addr[31:2];
    #1 cl = cfgClaim;
    @(negedge clk);
    cfgValid = 1'b0;
    d = cfgRdata; v = cfgRdValid;
  endtask

  function automatic string tagFor(input int n, input logic [31:0] v, input logic [31:0] mask);
    if (LEGACY[n]) return "R6";
    if (SIZES[n] == 0) return "R7";
    if (v == ONES) return "R2";
    if ((v & ~mask) == 0) return "R5";
    return "R4";
  endfunction

  task automatic checkDecode(input string req, input int n);
    check(req, barBase[n*32 +: 32], expBase[n]);
    check(req, {31'h0, barEnable[n]}, {31'h0, expEn[n]});
    check(req, {31'h0, barIsIo[n]}, {31'h0, expIo[n]});
  endtask

  task automatic barStep(input int n, input logic [31:0] v);
    logic [31:0] mask, src, rd;
    logic vld, cl;
    logic chgExp;
    string t;
    mask = expBar[n][0] ? 32'h3 : 32'hF;
    t = tagFor(n, v, mask);
    chgExp = 1'b0;
    if (!LEGACY[n] && SIZES[n] != 0) begin
      src = (v == ONES) ? ~(SIZES[n] - 32'd1) : v;
      if (v != ONES && (v & ~mask) != 0) begin
        expBase[n] = v & ~mask; expEn[n] = 1'b1; expIo[n] = expBar[n][0]; chgExp = 1'b1;
      end
      expBar[n] = (src & ~mask) | (expBar[n] & mask);
    end
    cfgWr(32'h0000_0810 + 32'(n*4), 4'hF, v);
    check({t, " R3 pulse"}, {31'h0, mapChange}, {31'h0, chgExp});
    cfgRd(32'h0000_0810 + 32'(n*4), rd, vld, cl);
    check({t, " R3 read"}, rd, expBar[n]);
    checkDecode(t, n);
  endtask

  initial begin
    logic [31:0] rd;
    logic vld, cl;
    for (int n = 0; n < 6; n++) begin
      expBar[n]  = (LEGACY[n] || SIZES[n] == 0) ? 32'h0 : {28'h0, TYPES[n]};
      expBase[n] = LEGACY[n] ? LBASE[n] : 32'h0;
      expEn[n]   = LEGACY[n];
      expIo[n]   = LEGACY[n];
    end
    repeat (4) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    check("R1 mapChange", {31'h0, mapChange}, 32'h0);
    cfgRd(32'h0000_0804, rd, vld, cl); check("R1 cmd/status", rd, 32'h0);
    cfgRd(32'h0000_080C, rd, vld, cl); check("R1 line/lat", rd, 32'h0);
    cfgRd(32'h0000_083C, rd, vld, cl); check("R1 intline", rd, 32'h0);
    for (int n = 0; n < 6; n++) begin
      cfgRd(32'h0000_0810 + 32'(n*4), rd, vld, cl);
      check("R1 bar reset", rd, expBar[n]);
      checkDecode("R1 decode reset", n);
    end

    // R11 claim and identification
    cfgRd(32'h0000_0800, rd, vld, cl);
    check("R11 id", rd, IDV);
    check("R11 valid", {31'h0, vld}, 32'h1);
    check("R11 claim", {31'h0, cl}, 32'h1);

    // R8 byte lanes
    cfgWr(32'h0000_080C, 4'b0001, 32'h0000_3310);
    cfgWr(32'h0000_080C, 4'b0010, 32'h0000_4477);
    cfgRd(32'h0000_080C, rd, vld, cl); check("R8 line/lat", rd, 32'h0000_4410);
    cfgWr(32'h0000_083C, 4'b0001, 32'h5555_550B);
    cfgRd(32'h0000_083C, rd, vld, cl); check("R8 intline", rd, 32'h0000_000B);
    cfgRd(32'h0000_080C, rd, vld, cl); check("R8 line untouched", rd, 32'h0000_4410);

    // R9 command/status
    cfgWr(32'h0000_0804, 4'b0011, 32'hFFFF_0147);
    cfgRd(32'h0000_0804, rd, vld, cl); check("R9 command", rd, 32'h0000_0147);
    cfgWr(32'h0000_0804, 4'b1100, 32'h0290_FFFF);
    cfgRd(32'h0000_0804, rd, vld, cl); check("R9 status", rd, 32'h0290_0147);

    // BAR sweep: probe, base, zero-base, second base, probe again
    for (int n = 0; n < 6; n++) begin
      barStep(n, ONES);
      barStep(n, 32'hA5A5_5A5F);
      barStep(n, 32'h0000_0003);
      barStep(n, 32'h0000_000C);
      barStep(n, 32'hDEAD_BEEF);
      barStep(n, ONES);
    end

    // R10 partial BAR writes ignored
    for (int n = 0; n < 6; n++) begin
      cfgWr(32'h0000_0810 + 32'(n*4), 4'b0111, 32'h1357_9BD0);
      check("R10 pulse", {31'h0, mapChange}, 32'h0);
      cfgRd(32'h0000_0810 + 32'(n*4), rd, vld, cl);
      check("R10 read", rd, expBar[n]);
      checkDecode("R10 decode", n);
    end

    // R11 unclaimed accesses
    cfgRd(32'h0000_0904, rd, vld, cl);
    check("R11 unclaimed claim", {31'h0, cl}, 32'h0);
    check("R11 unclaimed valid", {31'h0, vld}, 32'h0);
    cfgWr(32'h0000_0904, 4'hF, 32'h0000_FFFF);
    cfgRd(32'h0000_0804, rd, vld, cl); check("R11 unclaimed write", rd, 32'h0290_0147);

    // R12 function without a range
    check("R12 no claim", {31'h0, offClaim}, 32'h0);
    check("R12 no read", {31'h0, offRdValid}, 32'h0);
    cfgWr(32'hFFFF_FF14, 4'hF, 32'h4000_0000);
    check("R12 no pulse", {31'h0, offMapChange}, 32'h0);
    check("R12 no enable", {26'h0, offEnable}, 32'h0000_0010);
    check("R12 main untouched", {26'h0, barEnable}, {26'h0, expEn[5], expEn[4], expEn[3], expEn[2], expEn[1], expEn[0]});

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000 && !done) begin
      done = 1;
      nFail++;
      $display("FAIL watchdog actual=%0d expected=<50000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end
endmodule